// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block sits between two 18-bit buses, called A and B, and carries data across in each direction on its own path. Each path has a storage element with three modes. It can pass its input straight to the far side. It can hold a stored word. It can store a new word when the path's capture clock falls. A path's latch enable selects between the live input and the stored word. The path's capture clock loads the store only while the latch enable is low.

Neither side has true bidirectional pins. Each port has an 18-bit data output and a drive flag, and the surrounding logic resolves the wires. The A-to-B drive flag follows its enable with the same sense, so it is active high. The B-to-A enable is active low. All control inputs are sampled on a free-running system clock, so a fall of a capture clock is seen as a high sample followed by a low sample.

Each path is run by a three-state controller. The states are:
- `ST_PASS`: the latch enable is high, and the store tracks the input on every system edge.
- `ST_ARMED`: the latch enable is low, and the capture clock was last seen high.
- `ST_IDLE`: the latch enable is low, and the capture clock was last seen low.

The controller has these transitions:
- enable rises: any state goes to `ST_PASS`.
- close-high: `ST_PASS` goes to `ST_ARMED` when the enable drops while the clock is high.
- close-low: `ST_PASS` goes to `ST_IDLE` when the enable drops while the clock is low.
- fire: `ST_ARMED` goes to `ST_IDLE` on a low clock sample. This loads the store.
- arm: `ST_IDLE` goes to `ST_ARMED` on a high clock sample. This does not load the store.
- stay: a state with no change on its inputs keeps its state.

Top module: `ubt_xcvr`

## Requirements
- R1: Each path is 18 bits wide by default. Each port gives a data word plus a one-bit drive flag.
- R2: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle, without waiting for a clock edge.
- R3: With `ab_le` at 0, a system edge that samples `ab_clk` low after the previous edge sampled it high stores `a_in`. The stored word appears on `b_out` after that edge.
- R4: With `ab_le` at 0, a capture clock that stays steady or rises leaves the stored word and `b_out` unchanged, whatever `a_in` does.
- R5: When `ab_le` drops from 1 to 0, `b_out` keeps the `a_in` value sampled at the last system edge where `ab_le` was 1.
- R6: `b_drive` is 1 exactly when `ab_oe` is 1, so the enable is active high.
- R7: The B-to-A path follows R2 to R5, using `ba_le`, `ba_clk`, `b_in` and `a_out`.
- R8: `a_drive` is 1 exactly when `ba_oe_n` is 0, so the enable is active low.
- R9: An active-low asynchronous `rst_n` clears both stored words to zero at once and puts both controllers in `ST_IDLE`.
- R10: After the close-high transition, the first low sample of the capture clock stores the input (the fire transition).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 18 | Word received from the A bus |
| b_in | input | 18 | Word received from the B bus |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable |
| ab_clk | input | 1 | A-to-B capture clock, falling edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_clk | input | 1 | B-to-A capture clock, falling edge |
| b_out | output | 18 | Word presented to the B bus |
| b_drive | output | 1 | B port drives the bus when 1 |
| a_out | output | 18 | Word presented to the A bus |
| a_drive | output | 1 | A port drives the bus when 1 |

## Verification
A controller left in the wrong state shows itself one system edge after the next low clock sample. A store that fails to fire keeps the old word. A fire from `ST_IDLE` or on a rising clock loads a word that should not have been taken. A corrupted store stays hidden while the latch enable is high, because the output then shows the live input. It becomes visible in the first cycle after the enable drops. For that reason the bench lowers the latch enable after every transparent stretch and compares both outputs in every cycle. A swapped enable polarity shows on the drive flags in the same cycle.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
    localparam int unsigned UBT_WIDTH = 18;

    typedef enum logic [1:0] {
        ST_PASS  = 2'd0,
        ST_ARMED = 2'd1,
        ST_IDLE  = 2'd2
    } ubt_state_e;
endpackage

// File: rtl/ubt_path.sv
module ubt_path
    import ubt_pkg::*;
#(
    parameter int unsigned WIDTH = UBT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    input  logic             le,
    input  logic             cap_clk,
    output logic [WIDTH-1:0] q_out
);
    ubt_state_e       state_q, state_d;
    logic             load;
    logic [WIDTH-1:0] store_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and load strobe
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_PASS: begin
                if (le) begin
                    load = 1'b1;
                end else begin
                    state_d = cap_clk ? ST_ARMED : ST_IDLE;
                end
            end
            ST_ARMED: begin
                if (le) begin
                    state_d = ST_PASS;
                    load    = 1'b1;
                end else if (!cap_clk) begin
                    state_d = ST_IDLE;
                    load    = 1'b1;
                end
            end
            ST_IDLE: begin
                if (le) begin
                    state_d = ST_PASS;
                    load    = 1'b1;
                end else if (cap_clk) begin
                    state_d = ST_ARMED;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    store_q <= '0;
        else if (load) store_q <= d_in;
    end

    // output: live input when transparent, stored word otherwise
    always_comb begin
        q_out = le ? d_in : store_q;
    end
endmodule

// File: rtl/ubt_oe.sv
module ubt_oe #(
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic en_in,
    output logic drive_out
);
    generate
        if (ACTIVE_LOW) begin : g_low
            assign drive_out = ~en_in;
        end else begin : g_high
            assign drive_out = en_in;
        end
    endgenerate
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
    import ubt_pkg::*;
#(
    parameter int unsigned WIDTH = UBT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             ab_oe,
    input  logic             ab_le,
    input  logic             ab_clk,
    input  logic             ba_oe_n,
    input  logic             ba_le,
    input  logic             ba_clk,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drive,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive
);
    ubt_path #(.WIDTH(WIDTH)) u_ab (
        .clk(clk), .rst_n(rst_n), .d_in(a_in), .le(ab_le),
        .cap_clk(ab_clk), .q_out(b_out)
    );

    ubt_path #(.WIDTH(WIDTH)) u_ba (
        .clk(clk), .rst_n(rst_n), .d_in(b_in), .le(ba_le),
        .cap_clk(ba_clk), .q_out(a_out)
    );

    ubt_oe #(.ACTIVE_LOW(1'b0)) u_oe_b (.en_in(ab_oe),   .drive_out(b_drive));
    ubt_oe #(.ACTIVE_LOW(1'b1)) u_oe_a (.en_in(ba_oe_n), .drive_out(a_drive));
endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
    parameter int unsigned WIDTH = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             ab_oe,
    input logic             ab_le,
    input logic             ab_clk,
    input logic             ba_oe_n,
    input logic             ba_le,
    input logic             ba_clk,
    input logic [WIDTH-1:0] b_out,
    input logic             b_drive,
    input logic [WIDTH-1:0] a_out,
    input logic             a_drive
);
    AST_AB_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le |-> (b_out == a_in)); // R2

    AST_BA_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        ba_le |-> (a_out == b_in)); // R7

    AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !ab_clk && $past(!ab_clk)) |=> (ab_le || $stable(b_out))); // R4

    AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !ab_clk && $past(ab_clk) && $past(!ab_le))
        |=> (ab_le || b_out == $past(a_in))); // R3

    AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && !ba_clk && $past(ba_clk) && $past(!ba_le))
        |=> (ba_le || a_out == $past(b_in))); // R7

    AST_B_DRIVE_POL: assert property (@(posedge clk) disable iff (!rst_n)
        b_drive == ab_oe); // R6

    AST_A_DRIVE_POL: assert property (@(posedge clk) disable iff (!rst_n)
        a_drive != ba_oe_n); // R8
endmodule

bind ubt_xcvr ubt_xcvr_chk #(.WIDTH(WIDTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
);

// File: tb/ubt_xcvr_tb_top.sv
module ubt_xcvr_tb_top;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         ab_oe = 1'b0, ab_le = 1'b0, ab_clk = 1'b0;
    logic         ba_oe_n = 1'b1, ba_le = 1'b0, ba_clk = 1'b0;
    logic [W-1:0] b_out, a_out;
    logic         b_drive, a_drive;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    logic [W-1:0] m_ab = '0, m_ba = '0;
    bit arm_ab = 0, arm_ba = 0;

    always #10 clk = ~clk; // 50 MHz

    ubt_xcvr #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk),
        .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
    );

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Inputs are already set by the caller after a negedge.
    // Check mid low phase, then advance the model with the values the next posedge samples.
    task automatic step(input string req);
        #5;
        if (!rst_n) begin
            m_ab = '0; m_ba = '0; arm_ab = 0; arm_ba = 0;
        end
        chk(req, "b_out", b_out, ab_le ? a_in : m_ab);
        chk(req, "a_out", a_out, ba_le ? b_in : m_ba);
        chk(req, "b_drive", {{(W-1){1'b0}}, b_drive}, {{(W-1){1'b0}}, ab_oe});
        chk(req, "a_drive", {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, ~ba_oe_n});
        if (rst_n) begin
            if (ab_le) begin
                m_ab = a_in; arm_ab = 0;
            end else begin
                if (arm_ab && !ab_clk) m_ab = a_in;
                arm_ab = ab_clk;
            end
            if (ba_le) begin
                m_ba = b_in; arm_ba = 0;
            end else begin
                if (arm_ba && !ba_clk) m_ba = b_in;
                arm_ba = ba_clk;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        a_in = 18'h2AAAA; b_in = 18'h15555;
        step("R9"); step("R9");
        rst_n = 1'b1;
        step("R1");

        // transparent, both directions
        ab_le = 1; ba_le = 1; ab_oe = 1; ba_oe_n = 0;
        for (int i = 0; i < 4; i++) begin
            a_in = 18'h01234 + 18'(i * 18'h1111);
            b_in = 18'h3FFFF - 18'(i * 18'h0F0F);
            step("R2"); step("R7");
        end
        // close low then hold with changing inputs
        ab_le = 0; ba_le = 0; a_in = 18'h00F0F; b_in = 18'h3C3C3;
        step("R5"); step("R5");
        a_in = 18'h11111; b_in = 18'h22222; step("R4");
        // rising capture clocks do not store
        ab_clk = 1; ba_clk = 1; a_in = 18'h33333; b_in = 18'h0ABCD; step("R4");
        step("R4");
        // falling edge stores
        ab_clk = 0; ba_clk = 0; a_in = 18'h2BEEF; b_in = 18'h1CAFE; step("R3");
        a_in = 18'h00001; b_in = 18'h00002; step("R3"); step("R7");

        // close-high path then fire
        ab_le = 1; ba_le = 1; ab_clk = 1; ba_clk = 1; a_in = 18'h12345; b_in = 18'h23456;
        step("R2");
        ab_le = 0; ba_le = 0; a_in = 18'h0AAAA; b_in = 18'h05555; step("R10");
        ab_clk = 0; ba_clk = 0; a_in = 18'h3F00F; b_in = 18'h00FF0; step("R10");
        a_in = 18'h0; b_in = 18'h0; step("R10");

        // output enable polarity
        ab_oe = 0; ba_oe_n = 1; step("R6"); step("R8");
        ab_oe = 1; ba_oe_n = 1; step("R6");
        ab_oe = 0; ba_oe_n = 0; step("R8");

        // asynchronous reset clears stores
        rst_n = 0; step("R9");
        rst_n = 1; step("R9"); step("R9");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule